// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter built from identical narrow stages that are chained into one wider count. Every stage shares the clock, and they all update together on the rising edge. A stage can be preset from parallel data, cleared, advanced by one or frozen. Two enables control counting. The wide enable goes to every stage. The chain enable enters the lowest stage, and from there it ripples upward as each stage's all-ones indication.

The clear input is active low and has priority over everything else. A parameter makes it either asynchronous, so it takes effect at once, or synchronous, so it takes effect on the next rising edge. In the synchronous variant the counter can be given a shorter cycle. Logic outside the block decodes one count value and drives clear low from it. The terminal-count output is combinational, and it is meant to drive the chain enable of a further counter.

A separate system reset `rst_n` is asynchronous and active low. Its release is assumed to be synchronised upstream.

Top module: `casc_bin_counter`

## Requirements
- R1: While `rst_n` is low, `count` is zero.
- R2: A low on `clr_n` forces `count` to zero, overriding `load_n` and both enables. With `SYNC_CLEAR`=0 this happens without waiting for a clock edge. With `SYNC_CLEAR`=1 it happens at the next rising edge.
- R3: With `clr_n` high and `load_n` low, `load_data` appears on `count` after the next rising edge, whatever the levels of `cnt_en_p` and `cnt_en_t`.
- R4: With `clr_n` and `load_n` high and both `cnt_en_p` and `cnt_en_t` high, each rising edge adds one to `count`, modulo 2^(`STAGE_W`*`NUM_STAGES`).
- R5: With `clr_n` and `load_n` high, `count` keeps its value across an edge if `cnt_en_p` or `cnt_en_t` is low, each one on its own.
- R6: `tc_out` is high exactly when `cnt_en_t` is high and every bit of `count` is one. `cnt_en_p` has no effect on it, and it follows `cnt_en_t` without waiting for a clock edge.
- R7: A stage (bits `STAGE_W`*k and up) advances only on an edge where all lower bits are one. This includes the rollover from all ones to all zeros.
- R8: With `SYNC_CLEAR`=1, if `clr_n` is driven low whenever `count` equals K, the counter steps 0,1,...,K,0 and has period K+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| clr_n | input | 1 | Functional clear, active low; asynchronous or synchronous by `SYNC_CLEAR` |
| load_n | input | 1 | Parallel preset, active low |
| cnt_en_p | input | 1 | Count enable shared by every stage |
| cnt_en_t | input | 1 | Chain count enable into the lowest stage; also gates `tc_out` |
| load_data | input | STAGE_W*NUM_STAGES | Preset value |
| count | output | STAGE_W*NUM_STAGES | Current count |
| tc_out | output | 1 | Terminal count of the top stage |

## Verification
Two pairs of functions can meet in a single cycle. Clear can arrive together with a preset, and a preset can arrive while the counter is enabled and counting. The bench raises `clr_n` low and `load_n` low on the same edge, and expects zero rather than the load data. It also presets in the middle of an enabled run, and expects the load data rather than the incremented value. A bench-side model runs in both clear modes at once and judges every cycle, including the immediate clear of the asynchronous variant and the cycle-shortening feedback loop.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } cbc_mode_e;

endpackage

// File: rtl/cbc_mode_dec.sv
module cbc_mode_dec
  import cbc_pkg::*;
#(
  parameter bit SYNC_CLEAR = 1'b1
) (
  input  logic      clr_n,
  input  logic      load_n,
  input  logic      en_p,
  input  logic      en_t,
  output cbc_mode_e mode
);

  logic clr_hit;

  // only the synchronous variant sees clear in the next-state path
  assign clr_hit = SYNC_CLEAR && !clr_n;

  always_comb begin
    if (clr_hit)           mode = MODE_CLEAR;
    else if (!load_n)      mode = MODE_LOAD;
    else if (en_p && en_t) mode = MODE_COUNT;
    else                   mode = MODE_HOLD;
  end

endmodule

// File: rtl/cbc_stage.sv
module cbc_stage
  import cbc_pkg::*;
#(
  parameter int unsigned W          = 4,
  parameter bit          SYNC_CLEAR = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         tc
);

  cbc_mode_e    mode;
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         q_en;
  logic         arst_n;

  cbc_mode_dec #(
    .SYNC_CLEAR (SYNC_CLEAR)
  ) u_mode (
    .clr_n  (clr_n),
    .load_n (load_n),
    .en_p   (en_p),
    .en_t   (en_t),
    .mode   (mode)
  );

  // reset net: the asynchronous variant merges clear into it
  if (SYNC_CLEAR) begin : g_sync_clr
    assign arst_n = rst_n;
  end else begin : g_async_clr
    assign arst_n = rst_n & clr_n;
  end

  always_comb begin
    q_en  = 1'b1;
    q_nxt = q_r;
    case (mode)
      MODE_CLEAR: q_nxt = '0;
      MODE_LOAD:  q_nxt = d;
      MODE_COUNT: q_nxt = q_r + W'(1);
      default:    q_en  = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   q_r <= '0;
    else if (q_en) q_r <= q_nxt;
  end

  assign q  = q_r;
  assign tc = en_t & (&q_r);

endmodule

// File: rtl/casc_bin_counter.sv
module casc_bin_counter #(
  parameter int unsigned STAGE_W    = 4,
  parameter int unsigned NUM_STAGES = 2,
  parameter bit          SYNC_CLEAR = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_n,
  input  logic                          load_n,
  input  logic                          cnt_en_p,
  input  logic                          cnt_en_t,
  input  logic [STAGE_W*NUM_STAGES-1:0] load_data,
  output logic [STAGE_W*NUM_STAGES-1:0] count,
  output logic                          tc_out
);

  localparam int unsigned TOTAL_W = STAGE_W * NUM_STAGES;

  logic [NUM_STAGES:0] tc_chain;
  logic [TOTAL_W-1:0]  count_w;

  assign tc_chain[0] = cnt_en_t;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    cbc_stage #(
      .W          (STAGE_W),
      .SYNC_CLEAR (SYNC_CLEAR)
    ) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_n  (clr_n),
      .load_n (load_n),
      .en_p   (cnt_en_p),
      .en_t   (tc_chain[s]),
      .d      (load_data[s*STAGE_W +: STAGE_W]),
      .q      (count_w[s*STAGE_W +: STAGE_W]),
      .tc     (tc_chain[s+1])
    );
  end

  assign count  = count_w;
  assign tc_out = tc_chain[NUM_STAGES];

endmodule

// File: rtl/casc_bin_counter_chk.sv
module casc_bin_counter_chk #(
  parameter int unsigned STAGE_W    = 4,
  parameter int unsigned NUM_STAGES = 2,
  parameter bit          SYNC_CLEAR = 1'b1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          clr_n,
  input logic                          load_n,
  input logic                          cnt_en_p,
  input logic                          cnt_en_t,
  input logic [STAGE_W*NUM_STAGES-1:0] load_data,
  input logic [STAGE_W*NUM_STAGES-1:0] count,
  input logic                          tc_out
);

  localparam int unsigned TW = STAGE_W * NUM_STAGES;

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (count == '0));

  if (SYNC_CLEAR) begin : g_sync
    p_clear_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> (count == '0));
  end else begin : g_async
    p_clear_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> (count == '0));
  end

  p_load_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n) |=> ((count == $past(load_data)) || !clr_n));

  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && cnt_en_p && cnt_en_t)
      |=> ((count == TW'($past(count) + TW'(1))) || !clr_n));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !(cnt_en_p && cnt_en_t))
      |=> ((count == $past(count)) || !clr_n));

  p_tc_decode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out == (cnt_en_t && (&count)));

  if (NUM_STAGES > 1) begin : g_casc
    p_upper_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && load_n && !(&count[STAGE_W-1:0]))
        |=> ((count[TW-1:STAGE_W] == $past(count[TW-1:STAGE_W])) || !clr_n));
  end

endmodule

bind casc_bin_counter casc_bin_counter_chk #(
  .STAGE_W    (STAGE_W),
  .NUM_STAGES (NUM_STAGES),
  .SYNC_CLEAR (SYNC_CLEAR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_n     (clr_n),
  .load_n    (load_n),
  .cnt_en_p  (cnt_en_p),
  .cnt_en_t  (cnt_en_t),
  .load_data (load_data),
  .count     (count),
  .tc_out    (tc_out)
);

// File: tb/casc_bin_counter_bench.sv
module casc_bin_counter_bench;

  localparam int SW = 4;
  localparam int NS = 2;
  localparam int TW = SW * NS;
  localparam logic [TW-1:0] ALL1 = '1;

  logic          clk;
  logic          rst_n, clr_n, load_n, en_p, en_t;
  logic [TW-1:0] ld;
  logic [TW-1:0] q_s, q_a;
  logic          tc_s, tc_a;
  logic [TW-1:0] m_s, m_a;
  int            vectors = 0;
  int            fails   = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  casc_bin_counter #(.STAGE_W(SW), .NUM_STAGES(NS), .SYNC_CLEAR(1'b1)) u_casc_bin_counter (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n), .cnt_en_p(en_p),
    .cnt_en_t(en_t), .load_data(ld), .count(q_s), .tc_out(tc_s));

  casc_bin_counter #(.STAGE_W(SW), .NUM_STAGES(NS), .SYNC_CLEAR(1'b0)) u_casc_bin_counter_a (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n), .cnt_en_p(en_p),
    .cnt_en_t(en_t), .load_data(ld), .count(q_a), .tc_out(tc_a));

  task automatic chk(input string tag, input string what,
                     input logic [TW-1:0] act, input logic [TW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    chk(tag, "sync count", q_s, m_s);
    chk(tag, "async count", q_a, m_a);
    chk(tag, "sync tc", TW'(tc_s), TW'(en_t && (m_s == ALL1)));
    chk(tag, "async tc", TW'(tc_a), TW'(en_t && (m_a == ALL1)));
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic step(input logic ln, input logic p, input logic t, input logic c,
                      input logic [TW-1:0] d, input string tag);
    load_n = ln; en_p = p; en_t = t; clr_n = c; ld = d;
    #1;
    if (!c) begin
      m_a = '0;
      chk(tag, "async clear before edge", q_a, '0);
    end
    chk(tag, "tc follows chain enable", TW'(tc_s), TW'(t && (m_s == ALL1)));
    @(posedge clk);
    if (!c)               m_s = '0;
    else if (!ln)         m_s = d;
    else if (p && t)      m_s = m_s + TW'(1);
    if (!c)               m_a = '0;
    else if (!ln)         m_a = d;
    else if (p && t)      m_a = m_a + TW'(1);
    @(negedge clk);
    check_outputs(tag);
  endtask

  initial begin
    rst_n = 1'b0; clr_n = 1'b1; load_n = 1'b1; en_p = 1'b1; en_t = 1'b1; ld = 8'h5A;
    m_s = '0; m_a = '0;
    repeat (3) @(negedge clk);
    check_outputs("R1");
    rst_n = 1'b1;

    // R5: each enable low on its own holds the count
    step(1'b1, 1'b0, 1'b0, 1'b1, '0, "R5");
    step(1'b1, 1'b0, 1'b1, 1'b1, '0, "R5");
    step(1'b1, 1'b1, 1'b0, 1'b1, '0, "R5");

    // R4 then R7: count across the stage boundaries
    for (int i = 0; i < 15; i++) step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R4");
    for (int i = 0; i < 25; i++) step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R7");

    // R3: preset with both enables low
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'hFD, "R3");
    step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R6");
    step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R6");   // now all ones, tc high
    step(1'b1, 1'b0, 1'b1, 1'b1, '0, "R6");   // wide enable low: tc stays high
    step(1'b1, 1'b1, 1'b0, 1'b1, '0, "R6");   // chain enable low: tc low, hold
    step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R7");   // all ones to zero

    // R3: preset while counting
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R4");
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h3C, "R3");
    step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R3");

    // R2: clear together with preset, then with enables only
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'hA5, "R2");
    step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R2");
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h77, "R2");
    step(1'b1, 1'b1, 1'b1, 1'b0, '0, "R2");
    step(1'b1, 1'b1, 1'b1, 1'b1, '0, "R2");

    // R8: clear decoded from count 9 shortens the cycle to 10
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, "R8");
    for (int i = 0; i < 30; i++) begin
      step(1'b1, 1'b1, 1'b1, (q_s != 8'd9), '0, "R8");
      if (i % 10 == 9) chk("R8", "period", q_s, '0);
    end

    // mixed stimulus, all requirements
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 8) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
           ($urandom % 16) != 0, TW'($urandom), "R2/R3/R4/R5");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule